// File: doc/BRIEF.md
# Autoreload Compare Waveform Generator

This block drives one timer output pin with a repeating two-phase waveform. A shared free-running counter is supplied from outside. The block keeps its own compare register, and each time the counter arrives at that value the pin flips. In the same cycle the compare register moves forward by the length of the phase that has just begun. Software programs a high duration and a low duration and issues a start. After that no service is needed for each edge, and any duty cycle can be produced.

The compare arithmetic is 16 bits wide and wraps, so a phase that crosses the counter's rollover is timed correctly. A match counts only when the counter arrives at the compare value. A counter that advances more slowly than the block clock, and so holds each value for several cycles, still produces one edge per arrival.

Top module: `autoreload_wavegen`

## Requirements
- R1: When the counter input takes on a new value that equals the compare register while the generator is running, the pin toggles and `match_pulse` is high for exactly that one cycle. A counter that holds the value for several clocks yields only one match.
- R2: On a match, the compare register advances by `high_ticks` when the pin goes high and by `low_ticks` when the pin goes low.
- R3: A `start` sampled with `en` high loads the compare register with the current counter value plus `low_ticks` and forces the pin low, so the first phase is low.
- R4: The compare addition wraps modulo 65536, so phases that cross the counter's rollover last their programmed length.
- R5: A duration of 0 lasts 65536 counter steps, one full counter revolution.
- R6: `high_ticks` and `low_ticks` are read only at start and at a match. A change made mid-phase does not alter the running phase and takes effect from the next phase of that kind.
- R7: While `en` is low, the pin is low in the same cycle, no match occurs, the compare register is frozen and `start` is ignored. After `en` returns, the pin stays low until a new `start`.
- R8: After reset the pin is low, `match_pulse` is low, and the generator stays idle until a `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Generator enable |
| start | input | 1 | One-cycle strobe that arms the generator |
| count_in | input | 16 | Shared free-running counter value |
| high_ticks | input | 16 | Counter steps in the high phase (0 means 65536) |
| low_ticks | input | 16 | Counter steps in the low phase (0 means 65536) |
| wave_out | output | 1 | Waveform pin |
| match_pulse | output | 1 | High for one cycle on each compare match |

## Verification
A wrong compare value is not visible at the match where it is computed. It shows up one whole phase later, as an edge on the wrong counter value, and every later edge stays shifted by the same error. For that reason the bench records the counter value at every pin edge over several phases and compares each one with the running sum of the programmed durations. A wrong phase bit or a repeated match on a held counter value shows up at once, as an extra toggle or as a match pulse with no edge. Leaks through the disable gate show up on the first counter pass over the frozen compare value.

// File: rtl/autoreload_wavegen.sv
module autoreload_wavegen #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         start,
  input  logic [W-1:0] count_in,
  input  logic [W-1:0] high_ticks,
  input  logic [W-1:0] low_ticks,
  output logic         wave_out,
  output logic         match_pulse
);

  logic [W-1:0] cmp_q;
  logic [W-1:0] prev_q;
  logic         wave_q;
  logic         run_q;

  // arrival at the compare value, not dwell on it
  wire arrived = (count_in == cmp_q) && (count_in != prev_q);
  wire hit     = en && run_q && !start && arrived;

  // duration of the phase about to begin
  wire [W-1:0] next_len = wave_q ? low_ticks : high_ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q       <= '0;
      prev_q      <= '0;
      wave_q      <= 1'b0;
      run_q       <= 1'b0;
      match_pulse <= 1'b0;
    end else begin
      prev_q      <= count_in;
      match_pulse <= hit;
      if (!en) begin
        wave_q <= 1'b0;
        run_q  <= 1'b0;
      end else if (start) begin
        cmp_q  <= count_in + low_ticks;
        wave_q <= 1'b0;
        run_q  <= 1'b1;
      end else if (hit) begin
        cmp_q  <= cmp_q + next_len;
        wave_q <= ~wave_q;
      end
    end
  end

  assign wave_out = wave_q & en;

endmodule

module autoreload_wavegen_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         start,
  input logic [W-1:0] count_in,
  input logic [W-1:0] cmp_q,
  input logic         wave_q,
  input logic         wave_out,
  input logic         match_pulse
);

  p_toggle_on_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> wave_q != $past(wave_q));

  p_only_falls_without_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!match_pulse && wave_q != $past(wave_q)) |-> !wave_q);

  p_match_at_compare_r2: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> $past(count_in) == $past(cmp_q));

  p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start && en) |-> !wave_q);

  p_low_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !wave_out);

  p_frozen_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> (cmp_q == $past(cmp_q) && !match_pulse));

endmodule

bind autoreload_wavegen autoreload_wavegen_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .start(start), .count_in(count_in),
  .cmp_q(cmp_q), .wave_q(wave_q), .wave_out(wave_out), .match_pulse(match_pulse)
);

// File: tb/autoreload_wavegen_tb.sv
module autoreload_wavegen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        start = 1'b0;
  logic [15:0] cnt = '0;
  logic [15:0] high_ticks = '0;
  logic [15:0] low_ticks = '0;
  logic        wave_out;
  logic        match_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int div = 1;
  int sub = 0;

  always #10 clk = ~clk;

  autoreload_wavegen u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .start(start), .count_in(cnt),
    .high_ticks(high_ticks), .low_ticks(low_ticks),
    .wave_out(wave_out), .match_pulse(match_pulse)
  );

  function automatic int span(input logic [15:0] v);
    return (v == 0) ? 65536 : int'(v);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // advance the counter (every div cycles) and sample after the next edge
  task automatic step();
    sub++;
    if (sub >= div) begin
      sub = 0;
      cnt = cnt + 16'd1;
    end
    @(negedge clk);
  endtask

  task automatic arm(input logic [15:0] s, input logic [15:0] h, input logic [15:0] l);
    @(negedge clk);
    cnt = s; high_ticks = h; low_ticks = l; start = 1'b1; sub = 0;
    @(negedge clk);
    start = 1'b0;
    check("R3", "pin low after start", int'(wave_out), 0);
  endtask

  // watch edges; exp_at holds the counter value expected at each edge
  task automatic watch(input string req, input int exp_at[4], input int n, input int limit);
    logic prevw = 1'b0;
    int   k = 0;
    for (int t = 0; t < limit && k < n; t++) begin
      step();
      if (wave_out != prevw) begin
        check(req, "edge counter value", int'(cnt), exp_at[k] & 16'hFFFF);
        check(req, "edge polarity", int'(wave_out), (k % 2 == 0) ? 1 : 0);
        check("R1", "match with edge", int'(match_pulse), 1);
        prevw = wave_out;
        k++;
      end else if (match_pulse) begin
        check("R1", "match without edge", 1, 0);
      end
    end
    check(req, "edges seen", k, n);
  endtask

  task automatic run_wave(input string req, input logic [15:0] s, input logic [15:0] h,
                          input logic [15:0] l, input int n, input int d);
    int e[4];
    int acc;
    div = d;
    arm(s, h, l);
    acc = int'(s);
    for (int i = 0; i < 4; i++) begin
      acc = acc + ((i % 2 == 0) ? span(l) : span(h));
      e[i] = acc;
    end
    watch(req, e, n, (2 * span(h) + 2 * span(l) + 8) * d);
    div = 1;
  endtask

  task automatic t_reset();
    check("R8", "pin low in reset", int'(wave_out), 0);
    check("R8", "no match in reset", int'(match_pulse), 0);
    en = 1'b1;
    for (int i = 0; i < 30; i++) begin
      step();
      if (wave_out || match_pulse) check("R8", "idle before start", 1, 0);
    end
    check("R8", "idle before start", int'(wave_out), 0);
  endtask

  task automatic t_midupdate();
    int e[4];
    logic prevw = 1'b0;
    int k = 0;
    arm(16'd100, 16'd10, 16'd10);
    e[0] = 110; e[1] = 120; e[2] = 160; e[3] = 185;
    for (int t = 0; t < 200 && k < 4; t++) begin
      if (t == 3) low_ticks = 16'd40;
      if (k == 1 && wave_out) high_ticks = 16'd25;
      step();
      if (wave_out != prevw) begin
        check("R6", "edge counter value", int'(cnt), e[k]);
        prevw = wave_out;
        k++;
      end
    end
    check("R6", "edges seen", k, 4);
  endtask

  task automatic t_disable();
    int bad = 0;
    arm(16'd500, 16'd20, 16'd10);
    while (cnt != 16'd510) step();
    check("R2", "high before disable", int'(wave_out), 1);
    en = 1'b0;
    #1;
    check("R7", "pin drops with en", int'(wave_out), 0);
    for (int i = 0; i < 60; i++) begin
      start = (i == 10);
      step();
      if (wave_out || match_pulse) bad++;
    end
    start = 1'b0;
    check("R7", "activity while disabled", bad, 0);
    en = 1'b1;
    for (int i = 0; i < 80; i++) begin
      step();
      if (wave_out || match_pulse) bad++;
    end
    check("R7", "stays idle until new start", bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    run_wave("R2", 16'd50, 16'd1000, 16'd1000, 4, 1);
    run_wave("R2", 16'd7, 16'd2968, 16'd886, 4, 1);
    run_wave("R1", 16'd20, 16'd4, 16'd2, 4, 3);
    run_wave("R4", 16'hFF00, 16'h0100, 16'h0200, 4, 1);
    run_wave("R5", 16'd300, 16'd0, 16'd5, 2, 1);
    t_midupdate();
    t_disable();
    run_wave("R3", 16'd900, 16'd6, 16'd9, 4, 1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule